// File: doc/BRIEF.md
# Bit-Serial Accumulator with Slot-Gated Update

This block holds the 8-bit accumulator of a bit-serial processor. The register never takes a parallel write from the datapath. It changes in one of two ways. The first is a shift to the right by one place, with the bit on the single-wire serial data bus entering at the most significant end. The second is a single parallel step that moves the register one place to the left and takes a separate rotate-in bit into the least significant end.

A gating network looks at several inputs on every master clock cycle and decides whether a right shift happens: the machine phase (fetch or execute), the decoded operation flags and the current timing slot within the instruction cycle. Arithmetic, logical, clear and I/O-shift operations each produce a burst of eight shifts in slots 2 to 9. A rotate-right produces one shift in slot 13. During fetch the serial bus carries the incremented program counter, so nothing may reach the accumulator in that phase. An update counter, which wraps, comes out of the block so that the number of shifts per instruction can be observed.

Top module: `serial_acc_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `acc` and `upd_count` both become zero at that edge.
- R2: A right shift moves `acc[7:1]` into `acc[6:0]` and loads `ser_in` into `acc[7]`. A burst of eight shifts fed bits d0 first through d7 last therefore leaves `acc` equal to {d7..d0}.
- R3: In execute (`exec_phase`=1), with `op_add`, `op_inc` or `op_cmp` set, the accumulator right-shifts once on each clock whose `slot` is 2 through 9 inclusive. That is exactly eight shifts per instruction.
- R4: In execute, `op_clr`, `op_dep`, `op_and` and `op_ioshift` each produce the same eight right shifts in slots 2 through 9.
- R5: In execute with `op_rotr` set, exactly one right shift occurs, on the clock whose `slot` is 13.
- R6: In execute with `op_rotl` set, on the clock whose `slot` is 1, `acc` becomes {acc[6:0], rot_in}. If a right shift is requested on that same clock, the left step takes priority.
- R7: During fetch (`exec_phase`=0), `acc` never changes, whatever the operation flags, the slot, `ser_in` or `rot_in`.
- R8: `upd_count` increases by one, modulo 2^8, on every clock where `acc` is updated, and holds otherwise.
- R9: In execute with no operation flag set, `acc` is left unchanged across all slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; each rising edge is one potential shift pulse |
| rst_n | input | 1 | Synchronous active-low reset |
| exec_phase | input | 1 | 1 = execute phase, 0 = fetch phase |
| slot | input | 4 | Current timing slot index within the instruction cycle |
| op_add | input | 1 | Two's-complement add decoded |
| op_inc | input | 1 | Increment accumulator decoded |
| op_cmp | input | 1 | Complement accumulator decoded |
| op_clr | input | 1 | Clear accumulator decoded |
| op_dep | input | 1 | Deposit-and-clear decoded |
| op_and | input | 1 | Logical AND decoded |
| op_ioshift | input | 1 | I/O transfer shift sub-function decoded |
| op_rotr | input | 1 | Rotate-right decoded |
| op_rotl | input | 1 | Rotate-left decoded |
| ser_in | input | 1 | Serial data bus bit |
| rot_in | input | 1 | Bit entering the low end on a left step |
| acc | output | 8 | Accumulator contents |
| upd_count | output | 8 | Wrapping count of accumulator updates |

## Verification
Each update is decided combinationally from the inputs present before a rising edge and lands on that same edge. The result of the stimulus for slot k is therefore due one clock after it is applied. The bench drives each slot's inputs just after an edge and lets its behavioural model advance on the same inputs. It compares `acc` and `upd_count` one time unit after the next rising edge, on every clock. At the end of each instruction, whole-instruction checks confirm the final value and a count delta of 8, 1 or 0.

// File: rtl/sacc_pkg.sv
// Shared types for the serial accumulator.
// Assumes: operation flags come from an external decoder as one-hot-ish levels.
package sacc_pkg;

    // Decoded operation flags as seen by the accumulator gating.
    typedef struct packed {
        logic add;
        logic inc;
        logic cmp;
        logic clr;
        logic dep;
        logic land;
        logic ioshift;
        logic rotr;
        logic rotl;
    } sacc_ops_t;

    // Kind of update applied to the register on a given clock.
    typedef enum logic [1:0] {
        UPD_HOLD = 2'd0,
        UPD_SHR  = 2'd1,
        UPD_ROTL = 2'd2
    } sacc_upd_e;

endpackage

// File: rtl/sacc_shift_gate.sv
// Right-shift gating network.
// Decides, per master clock, whether the accumulator takes one serial bit.
// Assumes: slot is stable for the whole clock; exec_phase low means fetch.
module sacc_shift_gate
    import sacc_pkg::*;
#(
    parameter int SLOT_W      = 4,
    parameter int ACC_W       = 8,
    parameter int BURST_FIRST = 2,
    parameter int ROTR_SLOT   = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exec_phase,
    input  logic [SLOT_W-1:0] slot,
    input  sacc_ops_t         ops,
    output logic              shift_en
);
    localparam int BURST_LAST = BURST_FIRST + ACC_W - 1;
    localparam logic [SLOT_W-1:0] FIRST_S = SLOT_W'(BURST_FIRST);
    localparam logic [SLOT_W-1:0] LAST_S  = SLOT_W'(BURST_LAST);
    localparam logic [SLOT_W-1:0] RR_S    = SLOT_W'(ROTR_SLOT);

    logic in_burst;
    logic lvl_d;
    logic lvl_c;
    logic lvl_b;
    logic arith;
    logic rr_hit;

    // Build the condition tree: transfer ops, then clear, then slot window, then merge.
    always_comb begin
        in_burst = (slot >= FIRST_S) && (slot <= LAST_S);
        lvl_d    = ops.dep | ops.land | ops.ioshift;
        lvl_c    = ops.clr | lvl_d;
        lvl_b    = lvl_c & in_burst;
        arith    = (ops.add | ops.inc | ops.cmp) & in_burst;
        rr_hit   = ops.rotr & (slot == RR_S);
        shift_en = exec_phase & (lvl_b | arith | rr_hit);
    end

    // R3 R5 R7: a shift request only appears in execute inside the burst window or the rotate slot
    shift_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |-> (exec_phase && ((slot >= FIRST_S && slot <= LAST_S) || slot == RR_S)));

endmodule

// File: rtl/sacc_rotl_gate.sv
// Left-step enable.
// Fires once, when the rotate-left operation is decoded in execute and the
// slot that closes the first timing step is present.
// Assumes: the slot index is already aligned so that slot ROTL_SLOT ends at this edge.
module sacc_rotl_gate
    import sacc_pkg::*;
#(
    parameter int SLOT_W    = 4,
    parameter int ROTL_SLOT = 1
) (
    input  logic              exec_phase,
    input  logic [SLOT_W-1:0] slot,
    input  sacc_ops_t         ops,
    output logic              rotl_en
);
    localparam logic [SLOT_W-1:0] RL_S = SLOT_W'(ROTL_SLOT);

    // Qualify the rotate-left flag with phase and slot.
    always_comb begin
        rotl_en = exec_phase & ops.rotl & (slot == RL_S);
    end

endmodule

// File: rtl/sacc_shreg.sv
// Accumulator storage.
// Holds, shifts right with a serial bit entering at the top, or steps left
// taking a bit in at the bottom.
// Assumes: exactly one update kind is chosen per clock by the caller.
module sacc_shreg
    import sacc_pkg::*;
#(
    parameter int ACC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  sacc_upd_e        upd,
    input  logic             ser_in,
    input  logic             rot_in,
    output logic [ACC_W-1:0] q
);
    // Apply the selected update at the master clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            unique case (upd)
                UPD_SHR:  q <= {ser_in, q[ACC_W-1:1]};
                UPD_ROTL: q <= {q[ACC_W-2:0], rot_in};
                default:  q <= q;
            endcase
        end
    end

    // R2: a right shift places the serial bit at the top and moves the rest down
    shr_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd == UPD_SHR) |=> (q == {$past(ser_in), $past(q[ACC_W-1:1])}));

    // R6: a left step moves the rest up and takes the rotate-in bit at the bottom
    rotl_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd == UPD_ROTL) |=> (q == {$past(q[ACC_W-2:0]), $past(rot_in)}));

endmodule

// File: rtl/sacc_upd_counter.sv
// Wrapping update counter.
// Advances once per accumulator update so that per-instruction shift counts
// can be observed from outside.
module sacc_upd_counter
    import sacc_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  sacc_upd_e        upd,
    output logic [CNT_W-1:0] count
);
    // Count every clock that carries an update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (upd != UPD_HOLD) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/serial_acc_unit.sv
// Bit-serial accumulator top level.
// Combines the right-shift gating, the left-step enable, the register and the
// update counter. The left step takes priority over a right shift.
// Assumes: all inputs are synchronous to clk; reset is synchronous, active low.
module serial_acc_unit
    import sacc_pkg::*;
#(
    parameter int ACC_W       = 8,
    parameter int SLOT_W      = 4,
    parameter int CNT_W       = 8,
    parameter int BURST_FIRST = 2,
    parameter int ROTR_SLOT   = 13,
    parameter int ROTL_SLOT   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exec_phase,
    input  logic [SLOT_W-1:0] slot,
    input  logic              op_add,
    input  logic              op_inc,
    input  logic              op_cmp,
    input  logic              op_clr,
    input  logic              op_dep,
    input  logic              op_and,
    input  logic              op_ioshift,
    input  logic              op_rotr,
    input  logic              op_rotl,
    input  logic              ser_in,
    input  logic              rot_in,
    output logic [ACC_W-1:0]  acc,
    output logic [CNT_W-1:0]  upd_count
);
    sacc_ops_t ops;
    logic      shift_en;
    logic      rotl_en;
    sacc_upd_e upd;

    // Bundle the decoder flags.
    always_comb begin
        ops = '{add: op_add, inc: op_inc, cmp: op_cmp, clr: op_clr, dep: op_dep,
                land: op_and, ioshift: op_ioshift, rotr: op_rotr, rotl: op_rotl};
    end

    sacc_shift_gate #(
        .SLOT_W(SLOT_W), .ACC_W(ACC_W),
        .BURST_FIRST(BURST_FIRST), .ROTR_SLOT(ROTR_SLOT)
    ) u_gate (
        .clk(clk), .rst_n(rst_n), .exec_phase(exec_phase),
        .slot(slot), .ops(ops), .shift_en(shift_en)
    );

    sacc_rotl_gate #(
        .SLOT_W(SLOT_W), .ROTL_SLOT(ROTL_SLOT)
    ) u_rotl (
        .exec_phase(exec_phase), .slot(slot), .ops(ops), .rotl_en(rotl_en)
    );

    // Pick one update kind; the left step wins over a right shift.
    always_comb begin
        if (rotl_en)       upd = UPD_ROTL;
        else if (shift_en) upd = UPD_SHR;
        else               upd = UPD_HOLD;
    end

    sacc_shreg #(.ACC_W(ACC_W)) u_reg (
        .clk(clk), .rst_n(rst_n), .upd(upd),
        .ser_in(ser_in), .rot_in(rot_in), .q(acc)
    );

    sacc_upd_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .upd(upd), .count(upd_count)
    );

    // R7: the accumulator holds through fetch
    fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_phase |=> $stable(acc));

    // R6: left step and right shift are never both selected
    upd_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rotl_en && shift_en) |-> (upd == UPD_ROTL));

    // R8: any change of the accumulator is accompanied by one count step
    count_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc != $past(acc)) |-> (upd_count == $past(upd_count) + 1'b1));

    // R9: with no flag decoded the register holds
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ops == '0) |=> $stable(acc));

endmodule

// File: tb/serial_acc_unit_tb.sv
module serial_acc_unit_tb;
    localparam int CLK_PERIOD = 10;

    localparam logic [8:0] K_ADD  = 9'b100000000;
    localparam logic [8:0] K_INC  = 9'b010000000;
    localparam logic [8:0] K_CMP  = 9'b001000000;
    localparam logic [8:0] K_CLR  = 9'b000100000;
    localparam logic [8:0] K_DEP  = 9'b000010000;
    localparam logic [8:0] K_AND  = 9'b000001000;
    localparam logic [8:0] K_IOS  = 9'b000000100;
    localparam logic [8:0] K_RR   = 9'b000000010;
    localparam logic [8:0] K_RL   = 9'b000000001;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       exec_phase = 1'b0;
    logic [3:0] slot = '0;
    logic [8:0] opv = '0;
    logic       ser_in = 1'b0;
    logic       rot_in = 1'b0;
    logic [7:0] acc;
    logic [7:0] upd_count;

    int checks = 0;
    int failures = 0;
    int exp_acc = 0;
    int exp_cnt = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_acc_unit u_dut (
        .clk(clk), .rst_n(rst_n), .exec_phase(exec_phase), .slot(slot),
        .op_add(opv[8]), .op_inc(opv[7]), .op_cmp(opv[6]), .op_clr(opv[5]),
        .op_dep(opv[4]), .op_and(opv[3]), .op_ioshift(opv[2]),
        .op_rotr(opv[1]), .op_rotl(opv[0]),
        .ser_in(ser_in), .rot_in(rot_in), .acc(acc), .upd_count(upd_count)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Behavioural model step, then one clock, then compare.
    task automatic tick();
        if (!rst_n) begin
            exp_acc = 0;
            exp_cnt = 0;
        end else if (exec_phase && opv[0] && slot == 1) begin
            exp_acc = ((exp_acc << 1) | int'(rot_in)) & 255;
            exp_cnt = (exp_cnt + 1) % 256;
        end else if (exec_phase &&
                     (((opv[8:2] != 0) && slot >= 2 && slot <= 9) ||
                      (opv[1] && slot == 13))) begin
            exp_acc = (int'(ser_in) << 7) | (exp_acc >> 1);
            exp_cnt = (exp_cnt + 1) % 256;
        end
        @(posedge clk);
        #1;
        chk("R2/R8 per-cycle acc", int'(acc), exp_acc);
        chk("R8 per-cycle count", int'(upd_count), exp_cnt);
    endtask

    // One sixteen-slot instruction; data bits ride the bus in slots 2..9, bit 0 again in slot 13.
    task automatic run_instr(bit ex, logic [8:0] ops, logic [7:0] data, bit rin);
        exec_phase = ex;
        opv = ops;
        rot_in = rin;
        for (int s = 0; s < 16; s++) begin
            slot = 4'(s);
            if (s >= 2 && s <= 9) ser_in = data[s-2];
            else if (s == 13)     ser_in = data[0];
            else                  ser_in = 1'b1;
            tick();
        end
        opv = '0;
    endtask

    task automatic instr_chk(string req, bit ex, logic [8:0] ops, logic [7:0] data,
                             bit rin, int exp_val, int exp_delta);
        int c0;
        c0 = int'(upd_count);
        run_instr(ex, ops, data, rin);
        chk({req, " value"}, int'(acc), exp_val);
        chk({req, " shifts"}, (int'(upd_count) - c0 + 256) % 256, exp_delta);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int c0;
        #2;
        rst_n = 1'b0;
        for (int i = 0; i < 3; i++) tick();
        // R1: reset state
        chk("R1 acc reset", int'(acc), 0);
        chk("R1 count reset", int'(upd_count), 0);
        rst_n = 1'b1;

        // R3: arithmetic bursts load the serial word LSB first
        instr_chk("R3 add", 1, K_ADD, 8'hA5, 0, 'hA5, 8);
        instr_chk("R3 inc", 1, K_INC, 8'h3C, 0, 'h3C, 8);
        instr_chk("R3 cmp", 1, K_CMP, 8'h81, 0, 'h81, 8);
        // R2: bit order through a full burst
        instr_chk("R2 order", 1, K_ADD, 8'h01, 0, 'h01, 8);
        // R4: clear/transfer family
        instr_chk("R4 clr", 1, K_CLR, 8'h00, 0, 'h00, 8);
        instr_chk("R4 dep", 1, K_DEP, 8'h5A, 0, 'h5A, 8);
        instr_chk("R4 and", 1, K_AND, 8'hF0, 0, 'hF0, 8);
        instr_chk("R4 ioshift", 1, K_IOS, 8'h96, 0, 'h96, 8);
        // R5: rotate right, one pulse, bus bit 1 then 0
        instr_chk("R5 rotr one", 1, K_RR, 8'h01, 0, 'hCB, 1);
        instr_chk("R5 rotr zero", 1, K_RR, 8'h00, 0, 'h65, 1);
        // R6: left step with rot_in 1 then 0
        instr_chk("R6 rotl one", 1, K_RL, 8'hFF, 1, 'hCB, 1);
        instr_chk("R6 rotl zero", 1, K_RL, 8'hFF, 0, 'h96, 1);
        // R6: left step together with a burst op: left step in slot 1 then the burst
        instr_chk("R6 rotl+add", 1, K_RL | K_ADD, 8'h33, 1, 'h33, 9);
        // R7: fetch with every flag and a busy bus
        instr_chk("R7 fetch all", 0, 9'h1FF, 8'hFF, 1, 'h33, 0);
        instr_chk("R7 fetch add", 0, K_ADD, 8'hC3, 0, 'h33, 0);
        // R9: execute with no flags
        instr_chk("R9 idle", 1, 9'h000, 8'hFF, 1, 'h33, 0);
        // R8: 32 bursts = 256 updates wrap the counter to where it started
        c0 = int'(upd_count);
        for (int k = 0; k < 32; k++) run_instr(1, K_INC, 8'(k * 7), 0);
        chk("R8 wrap", int'(upd_count), c0);
        chk("R8 wrap acc", int'(acc), (31 * 7) & 255);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule